// File: doc/BRIEF.md
# Coalescing Delayed Interrupt Controller

This block holds the interrupt status and interrupt enable state of one device and drives a single level-sensitive interrupt line toward the host. Device logic posts events as bit vectors. The posted bits collect in a status register. The host reads that register, and the read clears it. The host can also rewrite the enable register at any time.

The block does not raise the line as soon as an enabled event arrives. It waits for a programmable number of cycles. It keeps at most one outstanding deadline in a down-counter. A new request can pull that deadline earlier but can never push it later, so a burst of events that falls inside one window produces a single assertion. While the line is already high, further events and expiring deadlines leave it high. The line stays up until a status read or an enable change leaves no enabled bit set.

Top module: `irqc_delayed_top`

## Requirements
- R1: After reset the interrupt line is low, and the status and enable registers both read zero.
- R2: A post ORs its bits into the status register. A status read returns the current status, and that status is zero after the read edge. Bits posted in the same cycle as the read survive it.
- R3: A write to the enable register is visible on its read port after the write edge.
- R4: The interrupt line is high only while the status AND enable is nonzero. Posted bits that are not enabled never raise it.
- R5: With the delay input at D >= 1 and no deadline outstanding, an enabled post sampled at edge k raises the line right after edge k+D, and the line stays low before that.
- R6: With the delay input at 0, an enabled post raises the line right after the edge that samples it.
- R7: When a deadline is outstanding and a new request would fire later, the new request is absorbed and the line rises at the earlier deadline.
- R8: When a new request would fire earlier than the outstanding deadline, the deadline moves to the new, earlier time.
- R9: While the line is high, further posts and expiring deadlines keep it high with no low cycle in between, so one assertion covers them all.
- R10: A status read that leaves no enabled bit set drops the line at that edge and cancels any outstanding deadline, so the line does not rise later from that deadline.
- R11: An enable write resolves the line at once: high after the write edge if status AND new enable is nonzero, low otherwise, whatever the delay setting.
- R12: A status read that arrives together with an enabled post leaves the line in its current state rather than dropping it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_vld | input | 1 | Event post strobe |
| post_bits | input | SW | Event bits to OR into status |
| stat_rd | input | 1 | Status read strobe; clears status at the edge |
| mask_we | input | 1 | Enable register write strobe |
| mask_wdata | input | SW | Enable register write data |
| hold_cycles | input | DW | Assertion delay in cycles |
| stat_rdata | output | SW | Current status register |
| mask_rdata | output | SW | Current enable register |
| irq_out | output | 1 | Level interrupt line to the host |

## Verification
A corrupted deadline counter shows up as a rising edge of irq_out on the wrong cycle. The bench therefore scores every cycle of each delay window, not only the cycle where the line should rise. A stale or missed status bit shows up one edge after the post or read on stat_rdata. A line that fails to drop, or that re-rises from a cancelled deadline, is caught because the bench checks the line low for the whole span in which the old deadline would have expired.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned STAT_W_DEF = 32;
    localparam int unsigned DLY_W_DEF  = 8;

    // Action chosen by the deadline counter each cycle
    typedef enum logic [1:0] {
        SCH_HOLD = 2'd0,   // keep counting down (or stay idle)
        SCH_LOAD = 2'd1,   // take a new, earlier deadline
        SCH_FIRE = 2'd2,   // deadline reached or immediate request
        SCH_DROP = 2'd3    // nothing live any more, forget the deadline
    } sch_act_e;

endpackage

// File: rtl/irqc_status.sv
module irqc_status #(
    parameter int unsigned SW = irqc_pkg::STAT_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          post_vld,
    input  logic [SW-1:0] post_bits,
    input  logic          stat_rd,
    input  logic          mask_we,
    input  logic [SW-1:0] mask_wdata,
    output logic [SW-1:0] isr_o,
    output logic [SW-1:0] imr_o,
    output logic          live_nx_o
);

    typedef struct packed {
        logic [SW-1:0] isr;
        logic [SW-1:0] imr;
    } stat_t;

    stat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // the read clears what was visible; posts of this cycle are kept
        if (stat_rd)  s_d.isr = '0;
        if (post_vld) s_d.isr = s_d.isr | post_bits;
        if (mask_we)  s_d.imr = mask_wdata;
        live_nx_o = |(s_d.isr & s_d.imr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign isr_o = s_q.isr;
    assign imr_o = s_q.imr;

endmodule

// File: rtl/irqc_deadline.sv
module irqc_deadline
    import irqc_pkg::*;
#(
    parameter int unsigned DW = irqc_pkg::DLY_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          cancel,
    input  logic [DW-1:0] delay,
    output logic          fire_o
);

    typedef struct packed {
        logic [DW-1:0] cnt;   // 0: no deadline; 1: deadline at this edge
    } tmr_t;

    tmr_t     t_d, t_q;
    sch_act_e act;
    logic     due;
    logic     earlier;

    always_comb begin
        due     = (t_q.cnt == DW'(1));
        // remaining edges of the old deadline are cnt-1
        earlier = (t_q.cnt == '0) || (delay < (t_q.cnt - DW'(1)));

        if (cancel)                    act = SCH_DROP;
        else if (req && delay == '0)   act = SCH_FIRE;
        else if (req && earlier)       act = SCH_LOAD;
        else if (due)                  act = SCH_FIRE;
        else                           act = SCH_HOLD;

        t_d = t_q;
        unique case (act)
            SCH_DROP,
            SCH_FIRE: t_d.cnt = '0;
            SCH_LOAD: t_d.cnt = delay;
            default:  t_d.cnt = (t_q.cnt == '0) ? '0 : t_q.cnt - DW'(1);
        endcase

        fire_o = (act == SCH_FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/irqc_delayed_top.sv
module irqc_delayed_top #(
    parameter int unsigned SW = irqc_pkg::STAT_W_DEF,
    parameter int unsigned DW = irqc_pkg::DLY_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          post_vld,
    input  logic [SW-1:0] post_bits,
    input  logic          stat_rd,
    input  logic          mask_we,
    input  logic [SW-1:0] mask_wdata,
    input  logic [DW-1:0] hold_cycles,
    output logic [SW-1:0] stat_rdata,
    output logic [SW-1:0] mask_rdata,
    output logic          irq_out
);

    typedef struct packed {
        logic irq;
    } line_t;

    line_t l_d, l_q;
    logic  live_nx;
    logic  sch_req;
    logic  sch_cancel;
    logic  sch_fire;

    irqc_status #(.SW(SW)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_vld   (post_vld),
        .post_bits  (post_bits),
        .stat_rd    (stat_rd),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .isr_o      (stat_rdata),
        .imr_o      (mask_rdata),
        .live_nx_o  (live_nx)
    );

    // an enable write resolves the line itself, so it never schedules
    assign sch_req    = post_vld & live_nx & ~mask_we;
    assign sch_cancel = ~live_nx | mask_we;

    irqc_deadline #(.DW(DW)) u_deadline (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (sch_req),
        .cancel (sch_cancel),
        .delay  (hold_cycles),
        .fire_o (sch_fire)
    );

    always_comb begin
        l_d = l_q;
        if (!live_nx)      l_d.irq = 1'b0;
        else if (mask_we)  l_d.irq = 1'b1;
        else if (sch_fire) l_d.irq = 1'b1;   // already high: no new edge
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign irq_out = l_q.irq;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned SW = 32,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          post_vld,
    input logic [SW-1:0] post_bits,
    input logic          stat_rd,
    input logic          mask_we,
    input logic [DW-1:0] hold_cycles,
    input logic [SW-1:0] stat_rdata,
    input logic [SW-1:0] mask_rdata,
    input logic          irq_out
);

    assert_post_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        post_vld |=> ((stat_rdata & $past(post_bits)) == $past(post_bits)));

    assert_line_needs_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|(stat_rdata & mask_rdata)));

    assert_zero_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && !mask_we && hold_cycles == '0 && |(post_bits & mask_rdata)) |=> irq_out);

    assert_hold_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !stat_rd && !mask_we) |=> irq_out);

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !post_vld && !mask_we) |=> !irq_out);

    assert_mask_resolves_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (irq_out == (|(stat_rdata & mask_rdata))));

endmodule

bind irqc_delayed_top irqc_checker #(.SW(SW), .DW(DW)) u_irqc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .post_vld    (post_vld),
    .post_bits   (post_bits),
    .stat_rd     (stat_rd),
    .mask_we     (mask_we),
    .hold_cycles (hold_cycles),
    .stat_rdata  (stat_rdata),
    .mask_rdata  (mask_rdata),
    .irq_out     (irq_out)
);

// File: tb/test_irqc_delayed_top.sv
`timescale 1ns/1ps
module test_irqc_delayed_top;

    localparam int SW = 32;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          post_vld = 1'b0;
    logic [SW-1:0] post_bits = '0;
    logic          stat_rd = 1'b0;
    logic          mask_we = 1'b0;
    logic [SW-1:0] mask_wdata = '0;
    logic [DW-1:0] hold_cycles = '0;
    logic [SW-1:0] stat_rdata;
    logic [SW-1:0] mask_rdata;
    logic          irq_out;

    always #2.5 clk = ~clk;

    irqc_delayed_top #(.SW(SW), .DW(DW)) i_irqc_delayed_top (
        .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_bits(post_bits),
        .stat_rd(stat_rd), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .hold_cycles(hold_cycles), .stat_rdata(stat_rdata),
        .mask_rdata(mask_rdata), .irq_out(irq_out)
    );

    // sel: 0 line, 1 status, 2 enable
    typedef struct {
        int            cyc;
        int            sel;
        logic [SW-1:0] val;
        string         rq;
    } exp_t;

    exp_t sb[$];
    int   ncyc  = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always @(posedge clk) ncyc <= ncyc + 1;

    // monitor: compare every expectation due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == ncyc) begin
                logic [SW-1:0] got;
                got = (sb[i].sel == 0) ? {{(SW-1){1'b0}}, irq_out} :
                      (sb[i].sel == 1) ? stat_rdata : mask_rdata;
                n_cmp++;
                if (got !== sb[i].val) begin
                    n_bad++;
                    $display("FAIL %s cycle %0d sel %0d: actual=%h expected=%h",
                             sb[i].rq, ncyc, sb[i].sel, got, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic push(int d, int sel, logic [SW-1:0] v, string rq);
        exp_t e;
        e.cyc = ncyc + d; e.sel = sel; e.val = v; e.rq = rq;
        sb.push_back(e);
    endtask

    task automatic push_irq(int d, bit v, string rq);
        push(d, 0, {{(SW-1){1'b0}}, v}, rq);
    endtask

    task automatic push_irq_span(int from, int to, bit v, string rq);
        for (int d = from; d <= to; d++) push_irq(d, v, rq);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        repeat (n) tick();
    endtask

    task automatic apply(bit pv, logic [SW-1:0] pb, bit rd, bit mw, logic [SW-1:0] md);
        post_vld = pv; post_bits = pb; stat_rd = rd; mask_we = mw; mask_wdata = md;
        tick();
        post_vld = 1'b0; post_bits = '0; stat_rd = 1'b0; mask_we = 1'b0; mask_wdata = '0;
    endtask

    task automatic clear_all(string rq);
        push_irq(1, 1'b0, rq);
        push(1, 1, '0, rq);
        apply(1'b0, '0, 1'b1, 1'b0, '0);
        idle(1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        push_irq(0, 1'b0, "R1");
        push(0, 1, '0, "R1");
        push(0, 2, '0, "R1");
        idle(1);

        // R3: enable write; R11 with nothing live keeps line low
        push(1, 2, 32'hF0, "R3");
        push_irq(1, 1'b0, "R11");
        apply(1'b0, '0, 1'b0, 1'b1, 32'hF0);
        idle(1);

        // R4 / R2: disabled bit posts, never raises line; read returns and clears
        hold_cycles = 8'd2;
        push(1, 1, 32'h1, "R2");
        push_irq_span(1, 5, 1'b0, "R4");
        apply(1'b1, 32'h1, 1'b0, 1'b0, '0);
        idle(5);
        push(0, 1, 32'h1, "R2");
        push(1, 1, '0, "R2");
        apply(1'b0, '0, 1'b1, 1'b0, '0);
        idle(1);

        // R5: delay of 3
        hold_cycles = 8'd3;
        push_irq_span(1, 3, 1'b0, "R5");
        push_irq(4, 1'b1, "R5");
        apply(1'b1, 32'h10, 1'b0, 1'b0, '0);
        idle(4);
        clear_all("R10");

        // R6: zero delay
        hold_cycles = 8'd0;
        push_irq(1, 1'b1, "R6");
        push(1, 1, 32'h20, "R6");
        apply(1'b1, 32'h20, 1'b0, 1'b0, '0);
        idle(1);
        clear_all("R10");

        // R7: later request absorbed by pending deadline
        hold_cycles = 8'd4;
        push_irq(1, 1'b0, "R7");
        apply(1'b1, 32'h10, 1'b0, 1'b0, '0);
        hold_cycles = 8'd8;
        push_irq_span(1, 3, 1'b0, "R7");
        push_irq_span(4, 6, 1'b1, "R7");
        apply(1'b1, 32'h40, 1'b0, 1'b0, '0);
        idle(6);
        clear_all("R10");

        // R8: earlier request pulls deadline in
        hold_cycles = 8'd10;
        push_irq(1, 1'b0, "R8");
        apply(1'b1, 32'h10, 1'b0, 1'b0, '0);
        hold_cycles = 8'd2;
        push_irq_span(1, 2, 1'b0, "R8");
        push_irq_span(3, 4, 1'b1, "R8");
        apply(1'b1, 32'h40, 1'b0, 1'b0, '0);
        idle(4);

        // R9: more posts while high, line never dips
        hold_cycles = 8'd0;
        push_irq(1, 1'b1, "R9");
        push(1, 1, 32'hD0, "R9");
        apply(1'b1, 32'h80, 1'b0, 1'b0, '0);
        hold_cycles = 8'd5;
        push_irq_span(1, 8, 1'b1, "R9");
        push(1, 1, 32'hD8, "R2");
        apply(1'b1, 32'h08, 1'b0, 1'b0, '0);
        idle(8);
        push(0, 1, 32'hD8, "R2");
        clear_all("R10");

        // R10: read before deadline cancels it
        hold_cycles = 8'd6;
        push_irq(1, 1'b0, "R10");
        apply(1'b1, 32'h10, 1'b0, 1'b0, '0);
        idle(1);
        push_irq_span(1, 9, 1'b0, "R10");
        apply(1'b0, '0, 1'b1, 1'b0, '0);
        idle(9);

        // R11: enable writes resolve line immediately
        hold_cycles = 8'd5;
        push(1, 1, 32'h1, "R11");
        push_irq(1, 1'b0, "R4");
        apply(1'b1, 32'h1, 1'b0, 1'b0, '0);
        idle(1);
        push_irq(1, 1'b1, "R11");
        push(1, 2, 32'hFF, "R3");
        apply(1'b0, '0, 1'b0, 1'b1, 32'hFF);
        idle(1);
        push_irq(1, 1'b0, "R11");
        apply(1'b0, '0, 1'b0, 1'b1, 32'h00);
        push_irq_span(1, 7, 1'b0, "R11");
        push(1, 2, 32'hF0, "R3");
        apply(1'b0, '0, 1'b0, 1'b1, 32'hF0);
        idle(7);
        clear_all("R2");

        // R12: read together with an enabled post keeps the line
        hold_cycles = 8'd0;
        push_irq(1, 1'b1, "R12");
        apply(1'b1, 32'h10, 1'b0, 1'b0, '0);
        hold_cycles = 8'd7;
        push_irq_span(1, 3, 1'b1, "R12");
        push(1, 1, 32'h20, "R12");
        apply(1'b1, 32'h20, 1'b1, 1'b0, '0);
        idle(3);
        clear_all("R10");

        idle(3);
        while (sb.size() != 0) tick();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all R): actual=timeout expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule